// File: doc/BRIEF.md
# Key-Locked Watchdog Timer with Wake-up and Reset Request

This block is a watchdog timer with a small synchronous register port. A free-running counter advances on a low-power tick enable. When the count crosses a selectable power-of-two interrupt period, the block raises a timeout flag that can drive a wake-up output. When the count crosses a separate reset period, it raises a reset-out flag. If reset-out is enabled, it also pulses a reset request for one cycle.

The control register is protected by a key lock. Software writes the unlock key to the lock register, changes the control register, and then writes any other value to relock it. Feeding the watchdog takes two key writes to the clear register, in the right order. A wrong value between them cancels the sequence. Flags are cleared by writing 1 to them. The reset-out enable cannot be changed while the reset-out flag is set.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset the control register is locked. Bit 0 of the lock register (address 0) reads 1 while locked and 0 while unlocked. Writing UNLOCK_KEY unlocks it, and writing any other value locks it.
- R2: A write to the control register (address 1) while it is locked leaves the register unchanged.
- R3: Control register fields: bit 0 is clock enable, bit 1 is timer enable, bit 2 is run-in-sleep, bits 6:4 are the interrupt period code and bits 10:8 are the reset period code. A write in which either code is NUM_PERIODS or higher is ignored completely.
- R4: The counter, read at address 5, advances by one on each cycle in which all of the following hold: lpTick is high, clock enable and timer enable are set, and either sleep is low or run-in-sleep is set. In every other cycle it holds its value.
- R5: The clear register is at address 4. Writing CLR_KEY_A and then, as the next clear-register write, CLR_KEY_B zeroes the counter at that edge. This clear takes priority over a tick in the same cycle, and that tick raises no flag. Any other value written as the second write cancels the sequence.
- R6: The flags register is at address 3. Bit 0 is the timeout flag and bit 1 is the reset-out flag. Writing 1 to a bit clears that flag. A flag that sets in the same cycle as its clear stays set.
- R7: The enable register is at address 2. Bit 0 is the wake-up enable and bit 1 is the reset-out enable. A write leaves bit 1 unchanged while the reset-out flag is set.
- R8: With period code c, a flag sets on a tick that brings the count to a value whose low BASE_EXP+c bits are all zero. The timeout flag uses the interrupt code and the reset-out flag uses the reset code.
- R9: wakeOut is high exactly while both the timeout flag and the wake-up enable are set.
- R10: rstReq is high for exactly one cycle, following each edge at which a reset-period crossing occurs while the reset-out enable is set.
- R11: Reset clears the control, enable, flags and counter, and leaves wakeOut and rstReq low. Reads of unused addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wrData | input | DATA_W | Write data |
| rdData | output | DATA_W | Read data for the register at addr (combinational) |
| lpTick | input | 1 | Low-power clock enable that advances the counter |
| sleep | input | 1 | System sleep indication |
| wakeOut | output | 1 | Wake-up request |
| rstReq | output | 1 | One-cycle reset request |

## Verification
Two pairs of events can land on the same edge: a period crossing and a software write that clears the flag, and a period crossing and the second clear key. The bench uses its reference model's count to find the cycle just before a crossing while lpTick runs every cycle. It then issues the flag clear, or the closing clear key, at exactly that edge. It judges the first case by the timeout flag staying set. It judges the second by the counter reading zero with no flag raised.

// File: rtl/keyed_watchdog_pkg.sv
package keyed_watchdog_pkg;

  localparam int CODE_W = 3;

  typedef enum logic [2:0] {
    REG_LOCK  = 3'd0,
    REG_CTRL  = 3'd1,
    REG_EN    = 3'd2,
    REG_FLAGS = 3'd3,
    REG_CLEAR = 3'd4,
    REG_COUNT = 3'd5
  } regSel_t;

  // Strobes and settings from the control side to the datapath
  typedef struct packed {
    logic              tick;
    logic              clrCount;
    logic              clrTo;
    logic              clrRst;
    logic              toEn;
    logic              rstEn;
    logic [CODE_W-1:0] intCode;
    logic [CODE_W-1:0] rstCode;
  } dpCmd_t;

endpackage

// File: rtl/keyed_watchdog_ctrl.sv
module keyed_watchdog_ctrl
  import keyed_watchdog_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W = 22,
  parameter int NUM_PERIODS = 6,
  parameter logic [DATA_W-1:0] UNLOCK_KEY = 'hA7,
  parameter logic [DATA_W-1:0] CLR_KEY_A = 'hD1,
  parameter logic [DATA_W-1:0] CLR_KEY_B = 'h2E
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [2:0]        addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              lpTick,
  input  logic              sleep,
  input  logic              toFlag,
  input  logic              rstFlag,
  input  logic [CNT_W-1:0]  count,
  output dpCmd_t            cmd,
  output logic [DATA_W-1:0] rdData
);

  localparam logic [CODE_W:0] NUM_P = NUM_PERIODS[CODE_W:0];

  logic              unlocked;
  logic              clkOn, runOn, slpRun;
  logic [CODE_W-1:0] intCode, rstCode;
  logic              toEn, rstEn;
  logic              armed;

  logic wrLock, wrCtrl, wrEnReg, wrFlags, wrClear;
  logic [CODE_W-1:0] newInt, newRst;
  logic codesOk, clrFire;

  assign wrLock  = wrEn && (addr == REG_LOCK);
  assign wrCtrl  = wrEn && (addr == REG_CTRL);
  assign wrEnReg = wrEn && (addr == REG_EN);
  assign wrFlags = wrEn && (addr == REG_FLAGS);
  assign wrClear = wrEn && (addr == REG_CLEAR);

  assign newInt  = wrData[6:4];
  assign newRst  = wrData[10:8];
  assign codesOk = ({1'b0, newInt} < NUM_P) && ({1'b0, newRst} < NUM_P);
  assign clrFire = wrClear && armed && (wrData == CLR_KEY_B);

  // Lock state
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       unlocked <= 1'b0;
    else if (wrLock) unlocked <= (wrData == UNLOCK_KEY);
  end

  // Control register, writable only while unlocked with legal codes
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkOn   <= 1'b0;
      runOn   <= 1'b0;
      slpRun  <= 1'b0;
      intCode <= '0;
      rstCode <= '0;
    end else if (wrCtrl && unlocked && codesOk) begin
      clkOn   <= wrData[0];
      runOn   <= wrData[1];
      slpRun  <= wrData[2];
      intCode <= newInt;
      rstCode <= newRst;
    end
  end

  // Enable register; reset-out enable frozen while its flag is up
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      toEn  <= 1'b0;
      rstEn <= 1'b0;
    end else if (wrEnReg) begin
      toEn <= wrData[0];
      if (!rstFlag) rstEn <= wrData[1];
    end
  end

  // Two-key clear sequencer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        armed <= 1'b0;
    else if (wrClear) armed <= !armed && (wrData == CLR_KEY_A);
  end

  always_comb begin
    cmd.tick     = lpTick && clkOn && runOn && (!sleep || slpRun);
    cmd.clrCount = clrFire;
    cmd.clrTo    = wrFlags && wrData[0];
    cmd.clrRst   = wrFlags && wrData[1];
    cmd.toEn     = toEn;
    cmd.rstEn    = rstEn;
    cmd.intCode  = intCode;
    cmd.rstCode  = rstCode;
  end

  always_comb begin
    rdData = '0;
    case (addr)
      REG_LOCK:  rdData[0] = !unlocked;
      REG_CTRL: begin
        rdData[0]    = clkOn;
        rdData[1]    = runOn;
        rdData[2]    = slpRun;
        rdData[6:4]  = intCode;
        rdData[10:8] = rstCode;
      end
      REG_EN: begin
        rdData[0] = toEn;
        rdData[1] = rstEn;
      end
      REG_FLAGS: begin
        rdData[0] = toFlag;
        rdData[1] = rstFlag;
      end
      REG_COUNT: rdData = DATA_W'(count);
      default:   rdData = '0;
    endcase
  end

  AST_LOCKED_CTRL: assert property (@(posedge clk) disable iff (!rstN)
    !unlocked |=> $stable({clkOn, runOn, slpRun, intCode, rstCode})); // R2
  AST_RSTEN_GUARD: assert property (@(posedge clk) disable iff (!rstN)
    rstFlag |=> $stable(rstEn)); // R7
  AST_CODES_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    ({1'b0, intCode} < NUM_P) && ({1'b0, rstCode} < NUM_P)); // R3

endmodule

// File: rtl/keyed_watchdog_dp.sv
module keyed_watchdog_dp
  import keyed_watchdog_pkg::*;
#(
  parameter int CNT_W = 22,
  parameter int BASE_EXP = 16,
  parameter int NUM_PERIODS = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCmd_t           cmd,
  output logic [CNT_W-1:0] count,
  output logic             toFlag,
  output logic             rstFlag,
  output logic             wakeOut,
  output logic             rstReq
);

  logic [CNT_W-1:0] maskTab [NUM_PERIODS];
  logic [CNT_W-1:0] intMask, rstMask, countNext;
  logic toHit, rstHit;

  for (genvar g = 0; g < NUM_PERIODS; g++) begin : gMask
    localparam int SH = CNT_W - BASE_EXP - g;
    assign maskTab[g] = {CNT_W{1'b1}} >> SH;
  end

  always_comb begin
    intMask = '0;
    rstMask = '0;
    for (int i = 0; i < NUM_PERIODS; i++) begin
      if (cmd.intCode == CODE_W'(i)) intMask = maskTab[i];
      if (cmd.rstCode == CODE_W'(i)) rstMask = maskTab[i];
    end
  end

  assign countNext = count + 1'b1;
  assign toHit  = cmd.tick && !cmd.clrCount && ((countNext & intMask) == '0);
  assign rstHit = cmd.tick && !cmd.clrCount && ((countNext & rstMask) == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             count <= '0;
    else if (cmd.clrCount) count <= '0;
    else if (cmd.tick)     count <= countNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      toFlag  <= 1'b0;
      rstFlag <= 1'b0;
      rstReq  <= 1'b0;
    end else begin
      toFlag  <= toHit  || (toFlag  && !cmd.clrTo);
      rstFlag <= rstHit || (rstFlag && !cmd.clrRst);
      rstReq  <= rstHit && cmd.rstEn;
    end
  end

  assign wakeOut = toFlag && cmd.toEn;

  AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    rstReq |=> !rstReq); // R10
  AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rstN)
    cmd.clrCount |=> (count == '0)); // R5
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (toFlag && !cmd.clrTo) |=> toFlag); // R6
  AST_COUNT_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (!cmd.tick && !cmd.clrCount) |=> $stable(count)); // R4

endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
  import keyed_watchdog_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BASE_EXP = 16,
  parameter int NUM_PERIODS = 6,
  parameter logic [DATA_W-1:0] UNLOCK_KEY = 'hA7,
  parameter logic [DATA_W-1:0] CLR_KEY_A = 'hD1,
  parameter logic [DATA_W-1:0] CLR_KEY_B = 'h2E
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [2:0]        addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic              lpTick,
  input  logic              sleep,
  output logic              wakeOut,
  output logic              rstReq
);

  localparam int CNT_W = BASE_EXP + NUM_PERIODS;

  dpCmd_t           cmd;
  logic [CNT_W-1:0] count;
  logic             toFlag, rstFlag;

  keyed_watchdog_ctrl #(
    .DATA_W(DATA_W), .CNT_W(CNT_W), .NUM_PERIODS(NUM_PERIODS),
    .UNLOCK_KEY(UNLOCK_KEY), .CLR_KEY_A(CLR_KEY_A), .CLR_KEY_B(CLR_KEY_B)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .lpTick(lpTick), .sleep(sleep), .toFlag(toFlag), .rstFlag(rstFlag),
    .count(count), .cmd(cmd), .rdData(rdData)
  );

  keyed_watchdog_dp #(
    .CNT_W(CNT_W), .BASE_EXP(BASE_EXP), .NUM_PERIODS(NUM_PERIODS)
  ) uDp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .count(count),
    .toFlag(toFlag), .rstFlag(rstFlag), .wakeOut(wakeOut), .rstReq(rstReq)
  );

endmodule

// File: tb/keyed_watchdog_test.sv
`timescale 1ns/1ps
module keyed_watchdog_test;

  localparam int DW = 32;
  localparam int BE = 2;
  localparam int NP = 6;
  localparam int CW = BE + NP;
  localparam logic [DW-1:0] UK = 'hA7;
  localparam logic [DW-1:0] KA = 'hD1;
  localparam logic [DW-1:0] KB = 'h2E;

  logic clk = 0, rstN = 0, wrEn = 0, lpTick = 0, sleep = 0;
  logic [2:0] addr = 0;
  logic [DW-1:0] wrData = 0;
  logic [DW-1:0] rdData;
  logic wakeOut, rstReq;

  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  keyed_watchdog #(.DATA_W(DW), .BASE_EXP(BE), .NUM_PERIODS(NP),
    .UNLOCK_KEY(UK), .CLR_KEY_A(KA), .CLR_KEY_B(KB)) uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .lpTick(lpTick), .sleep(sleep),
    .wakeOut(wakeOut), .rstReq(rstReq));

  // Behavioural reference state
  int mLocked, mClk, mRun, mSlp, mInt, mRst, mToEn, mRstEn;
  int mToF, mRstF, mCnt, mArmed, mReq;

  function automatic int expRd(input int a);
    case (a)
      0: return mLocked;
      1: return mClk + 2*mRun + 4*mSlp + 16*mInt + 256*mRst;
      2: return mToEn + 2*mRstEn;
      3: return mToF + 2*mRstF;
      5: return mCnt;
      default: return 0;
    endcase
  endfunction

  function automatic string tagOf(input int a);
    case (a)
      0: return "R1";
      1: return "R3";
      2: return "R7";
      3: return "R6";
      5: return "R4";
      default: return "R11";
    endcase
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      mLocked = 1; mClk = 0; mRun = 0; mSlp = 0; mInt = 0; mRst = 0;
      mToEn = 0; mRstEn = 0; mToF = 0; mRstF = 0; mCnt = 0; mArmed = 0; mReq = 0;
    end else begin
      int d, tk, clr, nc, toH, rsH;
      int nLocked, nArmed, nToEn, nRstEn;
      d = int'(wrData);
      tk = (lpTick && mClk && mRun && (!sleep || mSlp)) ? 1 : 0;
      clr = (wrEn && addr == 4 && mArmed && wrData == KB) ? 1 : 0;
      toH = 0; rsH = 0;
      nc = (mCnt + 1) % (1 << CW);
      if (tk && !clr) begin
        toH = (nc % (1 << (BE + mInt)) == 0) ? 1 : 0;
        rsH = (nc % (1 << (BE + mRst)) == 0) ? 1 : 0;
      end
      nLocked = mLocked; nArmed = mArmed; nToEn = mToEn; nRstEn = mRstEn;
      if (wrEn && addr == 0) nLocked = (wrData == UK) ? 0 : 1;
      if (wrEn && addr == 1 && !mLocked && ((d >> 4) % 8) < NP && ((d >> 8) % 8) < NP) begin
        mClk = d % 2; mRun = (d >> 1) % 2; mSlp = (d >> 2) % 2;
        mInt = (d >> 4) % 8; mRst = (d >> 8) % 8;
      end
      if (wrEn && addr == 2) begin
        nToEn = d % 2;
        if (!mRstF) nRstEn = (d >> 1) % 2;
      end
      if (wrEn && addr == 4) nArmed = (!mArmed && wrData == KA) ? 1 : 0;
      mReq = (rsH && mRstEn) ? 1 : 0;
      mToF  = (toH || (mToF  && !(wrEn && addr == 3 && d % 2 == 1))) ? 1 : 0;
      mRstF = (rsH || (mRstF && !(wrEn && addr == 3 && (d >> 1) % 2 == 1))) ? 1 : 0;
      if (clr) mCnt = 0; else if (tk) mCnt = nc;
      mLocked = nLocked; mArmed = nArmed; mToEn = nToEn; mRstEn = nRstEn;
    end
    #1;
    if (rstN) begin
      check(tagOf(int'(addr)), int'(rdData), expRd(int'(addr)));
      check("R9", int'(wakeOut), (mToF && mToEn) ? 1 : 0);
      check("R10", int'(rstReq), mReq);
    end
  end

  task automatic wr(input int a, input logic [DW-1:0] d);
    @(negedge clk); wrEn = 1; addr = 3'(a); wrData = d;
    @(negedge clk); wrEn = 0;
  endtask

  task automatic pulse(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); lpTick = 1;
      @(negedge clk); lpTick = 0;
    end
  endtask

  task automatic rd(input int a, input int exp, input string tag);
    addr = 3'(a); #1;
    check(tag, int'(rdData), exp);
  endtask

  task automatic finishRun;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    finishRun();
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R11: reset state
    rd(0, 1, "R11"); rd(1, 0, "R11"); rd(2, 0, "R11"); rd(3, 0, "R11");
    rd(5, 0, "R11"); rd(7, 0, "R11");
    check("R11", int'(wakeOut), 0); check("R11", int'(rstReq), 0);

    wr(1, 'h7);            rd(1, 0, "R2");
    wr(0, UK);             rd(0, 0, "R1");
    wr(1, 'h213);          rd(1, 'h213, "R3");
    wr(1, 'h763);          rd(1, 'h213, "R3");
    wr(0, 'h0);            rd(0, 1, "R1");
    wr(2, 3);              rd(2, 3, "R7");

    pulse(7); rd(5, 7, "R4"); rd(3, 0, "R8");
    pulse(1); rd(3, 1, "R8"); check("R9", int'(wakeOut), 1);
    pulse(7); rd(5, 15, "R4");
    pulse(1); rd(3, 3, "R8"); check("R10", int'(rstReq), 1);
    @(negedge clk); check("R10", int'(rstReq), 0);

    sleep = 1; pulse(3); rd(5, 16, "R4");
    wr(0, UK); wr(1, 'h217); wr(0, 'h1);
    pulse(2); rd(5, 18, "R4");
    sleep = 0;

    wr(2, 1);  rd(2, 3, "R7");
    wr(3, 2);  rd(3, 1, "R6");
    wr(2, 1);  rd(2, 1, "R7");
    wr(3, 1);  rd(3, 0, "R6"); check("R9", int'(wakeOut), 0);

    wr(4, KA); wr(4, 'h5); wr(4, KB); rd(5, 18, "R5");
    wr(4, KA); wr(4, KB);             rd(5, 0, "R5");

    // Crossing and flag clear on the same edge
    lpTick = 1;
    while (!mToF) @(negedge clk);
    while (((mCnt + 1) % 8) != 0) @(negedge clk);
    wrEn = 1; addr = 3; wrData = 1;
    @(negedge clk); wrEn = 0;
    rd(3, mToF + 2*mRstF, "R6");
    check("R6", int'(rdData) % 2, 1);

    // Crossing and closing clear key on the same edge
    while (((mCnt + 1) % 8) != 2) @(negedge clk);
    wrEn = 1; addr = 3; wrData = 3;
    @(negedge clk); addr = 4; wrData = KA;
    while (((mCnt + 1) % 8) != 0) @(negedge clk);
    wrData = KB;
    @(negedge clk); wrEn = 0; lpTick = 0;
    rd(5, 0, "R5"); rd(3, 0, "R5");

    repeat (3) @(negedge clk);
    finishRun();
  end

endmodule